// File: doc/BRIEF.md
# Streaming Frame-Difference Pixel Processor

This block sits behind the analogue-to-digital converters of a monolithic pixel sensor and turns a raw stream of 12-bit pixel samples into signed frame-to-frame differences. Each incoming sample is compared with the value that the same pixel produced one frame earlier. The difference is then narrowed by discarding low-order bits, and the result leaves the block in the same order the samples arrived. The low-order bits are dropped because the lowest converter bit toggles even when the input is constant.

Samples arrive one per clock at full rate, each with a pixel index and a start-of-frame marker. The block cannot stall its source. An on-chip previous-frame store, one word per pixel, holds the last value of every pixel. Its size comes from the row and column parameters, so simulations can use a small matrix while the nominal sensor is 360 by 640 at a 50 MHz pixel rate. Nothing is emitted until a full reference frame has been loaded after reset.

Top module: `cds_frame_diff`

## Requirements
- R1: While `rst_n` is low, and right after its release, `out_valid`, `out_sof` and `out_diff` are all zero.
- R2: After reset, valid samples seen before the first sample with `in_sof` high are discarded. They produce no output and do not change the store.
- R3: The frame that begins with the first `in_sof` after reset is the reference frame. Its samples are written to the store and produce no output.
- R4: From the second `in_sof` onward, every valid sample produces one output. Its raw difference is the sample minus the most recent earlier accepted sample of the same pixel index. That difference is 13-bit two's complement.
- R5: Every accepted sample replaces the stored value of its pixel in the same cycle it is read (read-before-write). Repeated samples of one index in consecutive cycles therefore see each other.
- R6: The raw difference is reduced by an arithmetic right shift of `SHIFT` bits, which rounds toward minus infinity (for example, -3 shifted by 1 gives -2).
- R7: The shifted value saturates to the signed `OUT_W`-bit range. With the defaults this range is -128 to +127.
- R8: A sample taken at rising edge n appears on the outputs right after edge n+2, a fixed latency of 3 cycles. Back-to-back samples are accepted every clock, and a cycle with `in_valid` low produces a cycle with `out_valid` low.
- R9: `out_sof` is high exactly on the output that belongs to a sample carrying `in_sof`, and never while `out_valid` is low.
- R10: `out_diff` is zero whenever `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample present this cycle |
| in_sof | input | 1 | Sample is the first of a frame |
| in_pix | input | $clog2(ROWS*COLS) | Pixel index of the sample |
| in_sample | input | SAMPLE_W (12) | Raw converter code, unsigned |
| out_valid | output | 1 | Difference present this cycle |
| out_sof | output | 1 | Difference is the first of a frame |
| out_diff | output | OUT_W (8) | Reduced, saturated signed difference |

## Verification
The assertions assume that every pixel index is below ROWS*COLS. They also assume that each frame presents every pixel, so a stored value always comes from the previous frame. The store-forwarding check assumes that the store's write enable and address come only from the input stage. The stimulus sends complete frames of all indices in order and inserts idle cycles only between samples, never with an out-of-range index. The discarded pre-frame samples also stay in range. The frames are chosen to push the difference into both saturation limits and into odd negative values, so that the rounding direction is exercised.

// File: rtl/fdp_pkg.sv
package fdp_pkg;

    // Frame tracking phase after reset
    typedef enum logic [1:0] {
        PH_WAIT = 2'd0,   // waiting for the first frame marker
        PH_LOAD = 2'd1,   // loading the reference frame
        PH_RUN  = 2'd2    // emitting differences
    } phase_e;

endpackage

// File: rtl/fdp_phase.sv
module fdp_phase
    import fdp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic in_sof,
    output logic wr_en,
    output logic emit
);

    phase_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        wr_en   = 1'b0;
        emit    = 1'b0;
        if (in_valid) begin
            case (state_q)
                PH_WAIT: begin
                    if (in_sof) begin
                        state_d = PH_LOAD;
                        wr_en   = 1'b1;
                    end
                end
                PH_LOAD: begin
                    wr_en = 1'b1;
                    if (in_sof) begin
                        state_d = PH_RUN;
                        emit    = 1'b1;
                    end
                end
                default: begin
                    wr_en = 1'b1;
                    emit  = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_WAIT;
        else        state_q <= state_d;
    end

    // R3
    no_skip_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_RUN) |-> ($past(state_q) != PH_WAIT));

    // R2
    wait_no_emit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_WAIT) |-> !emit);

endmodule

// File: rtl/fdp_store.sv
module fdp_store #(
    parameter int DEPTH  = 64,
    parameter int ADDR_W = 6,
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_d, rd_q;

    always_comb begin
        rd_d = mem[addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    assign rdata = rd_q;

    // R5
    rd_after_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && $past(wr_en) && addr == $past(addr)) |=> (rdata == $past(wdata, 2)));

endmodule

// File: rtl/fdp_reduce.sv
module fdp_reduce #(
    parameter int SAMPLE_W = 12,
    parameter int SHIFT    = 1,
    parameter int OUT_W    = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    emit,
    input  logic                    sof,
    input  logic [SAMPLE_W-1:0]     cur,
    input  logic [SAMPLE_W-1:0]     prev,
    output logic                    out_valid,
    output logic                    out_sof,
    output logic signed [OUT_W-1:0] out_diff
);

    localparam int DIFF_W = SAMPLE_W + 1;
    localparam int HI_I   = (1 << (OUT_W - 1)) - 1;
    localparam int LO_I   = -HI_I - 1;
    localparam logic signed [DIFF_W-1:0] HI_LIM = HI_I[DIFF_W-1:0];
    localparam logic signed [DIFF_W-1:0] LO_LIM = LO_I[DIFF_W-1:0];

    typedef struct packed {
        logic                    valid;
        logic                    sof;
        logic signed [OUT_W-1:0] diff;
    } res_t;

    res_t res_d, res_q;
    logic signed [DIFF_W-1:0] raw;
    logic signed [DIFF_W-1:0] shifted;
    logic signed [OUT_W-1:0]  clipped;

    always_comb begin
        raw     = $signed({1'b0, cur}) - $signed({1'b0, prev});
        shifted = raw >>> SHIFT;
    end

    generate
        if (OUT_W >= DIFF_W - SHIFT) begin : g_fit
            always_comb clipped = OUT_W'(shifted);
        end else begin : g_clip
            always_comb begin
                if (shifted > HI_LIM)      clipped = OUT_W'(HI_LIM);
                else if (shifted < LO_LIM) clipped = OUT_W'(LO_LIM);
                else                       clipped = OUT_W'(shifted);
            end
        end
    endgenerate

    always_comb begin
        res_d = '0;
        if (emit) begin
            res_d.valid = 1'b1;
            res_d.sof   = sof;
            res_d.diff  = clipped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign out_valid = res_q.valid;
    assign out_sof   = res_q.sof;
    assign out_diff  = res_q.diff;

endmodule

// File: rtl/cds_frame_diff.sv
module cds_frame_diff #(
    parameter int ROWS     = 8,
    parameter int COLS     = 8,
    parameter int SAMPLE_W = 12,
    parameter int SHIFT    = 1,
    parameter int OUT_W    = 8,
    localparam int NPIX    = ROWS * COLS,
    localparam int ADDR_W  = (NPIX > 1) ? $clog2(NPIX) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic                    in_sof,
    input  logic [ADDR_W-1:0]       in_pix,
    input  logic [SAMPLE_W-1:0]     in_sample,
    output logic                    out_valid,
    output logic                    out_sof,
    output logic signed [OUT_W-1:0] out_diff
);

    typedef struct packed {
        logic                wr;
        logic                emit;
        logic                sof;
        logic [ADDR_W-1:0]   pix;
        logic [SAMPLE_W-1:0] sample;
    } stg1_t;

    typedef struct packed {
        logic                emit;
        logic                sof;
        logic [SAMPLE_W-1:0] sample;
    } stg2_t;

    stg1_t s1_d, s1_q;
    stg2_t s2_d, s2_q;
    logic  ph_wr, ph_emit;
    logic [SAMPLE_W-1:0] old_val;

    fdp_phase u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .wr_en    (ph_wr),
        .emit     (ph_emit)
    );

    always_comb begin
        s1_d        = '0;
        s1_d.wr     = ph_wr;
        s1_d.emit   = ph_emit;
        s1_d.sof    = in_sof & ph_emit;
        s1_d.pix    = in_pix;
        s1_d.sample = in_sample;
        s2_d        = '0;
        s2_d.emit   = s1_q.emit;
        s2_d.sof    = s1_q.sof;
        s2_d.sample = s1_q.sample;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= s1_d;
            s2_q <= s2_d;
        end
    end

    fdp_store #(
        .DEPTH  (NPIX),
        .ADDR_W (ADDR_W),
        .DATA_W (SAMPLE_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (s1_q.wr),
        .addr  (s1_q.pix),
        .wdata (s1_q.sample),
        .rdata (old_val)
    );

    fdp_reduce #(
        .SAMPLE_W (SAMPLE_W),
        .SHIFT    (SHIFT),
        .OUT_W    (OUT_W)
    ) u_reduce (
        .clk       (clk),
        .rst_n     (rst_n),
        .emit      (s2_q.emit),
        .sof       (s2_q.sof),
        .cur       (s2_q.sample),
        .prev      (old_val),
        .out_valid (out_valid),
        .out_sof   (out_sof),
        .out_diff  (out_diff)
    );

    // R8
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid, 3));

    // R9
    sof_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_sof == $past(in_sof, 3)));

    // R9
    sof_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_sof |-> out_valid);

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_diff == '0));

endmodule

// File: tb/test_cds_frame_diff.sv
module test_cds_frame_diff;

    localparam int ROWS = 8;
    localparam int COLS = 8;
    localparam int NPIX = ROWS * COLS;
    localparam int AW   = $clog2(NPIX);
    localparam int SW   = 12;
    localparam int SH   = 1;
    localparam int OW   = 8;
    localparam int HI   = (1 << (OW - 1)) - 1;
    localparam int LO   = -HI - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_sof = 1'b0;
    logic [AW-1:0] in_pix = '0;
    logic [SW-1:0] in_sample = '0;
    logic out_valid, out_sof;
    logic signed [OW-1:0] out_diff;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    int    phase = 0;
    int    ref_mem [NPIX];
    bit    pv [3];
    bit    ps [3];
    int    pd [3];
    string pt [3];
    int    stim_prev [NPIX];

    always #4 clk = ~clk;

    cds_frame_diff #(
        .ROWS(ROWS), .COLS(COLS), .SAMPLE_W(SW), .SHIFT(SH), .OUT_W(OW)
    ) i_cds_frame_diff (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
        .in_pix(in_pix), .in_sample(in_sample),
        .out_valid(out_valid), .out_sof(out_sof), .out_diff(out_diff)
    );

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) begin
            pv[i] = 0; ps[i] = 0; pd[i] = 0; pt[i] = "R1";
        end
    end

    // behavioural model, advanced at each rising edge
    always @(posedge clk) begin
        bit    ev, es;
        int    ed, d, s;
        string et;
        ev = 0; es = 0; ed = 0; et = "R8 idle";
        if (!rst_n) begin
            phase = 0;
            et = "R1";
        end else if (in_valid) begin
            if (phase == 0) begin
                if (in_sof) begin
                    phase = 1;
                    ref_mem[in_pix] = int'(in_sample);
                    et = "R3";
                end else begin
                    et = "R2";
                end
            end else if (phase == 1 && !in_sof) begin
                ref_mem[in_pix] = int'(in_sample);
                et = "R3";
            end else begin
                phase = 2;
                d = int'(in_sample) - ref_mem[in_pix];
                s = d >>> SH;
                et = ((d < 0) && (d % 2 != 0)) ? "R6" : "R4";
                if (s > HI) begin s = HI; et = "R7"; end
                if (s < LO) begin s = LO; et = "R7"; end
                ref_mem[in_pix] = int'(in_sample);
                ev = 1; es = in_sof; ed = s;
            end
        end
        pv[2] = pv[1]; ps[2] = ps[1]; pd[2] = pd[1]; pt[2] = pt[1];
        pv[1] = pv[0]; ps[1] = ps[0]; pd[1] = pd[0]; pt[1] = pt[0];
        pv[0] = ev;    ps[0] = es;    pd[0] = ed;    pt[0] = et;
    end

    // compare away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check({pt[2], " R8 valid"}, int'(out_valid), int'(pv[2]));
            check({pt[2], " R9 sof"}, int'(out_sof), int'(ps[2]));
            check(pv[2] ? {pt[2], " diff"} : {pt[2], " R10 diff"},
                  int'(out_diff), pd[2]);
        end
    end

    task automatic send(bit sof, int pix, int val);
        @(negedge clk);
        in_valid  = 1'b1;
        in_sof    = sof;
        in_pix    = AW'(pix);
        in_sample = SW'(val);
        stim_prev[pix] = val;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_sample = '0;
        end
    endtask

    function automatic int clamp12(int v);
        if (v < 0) return 0;
        if (v > 4095) return 4095;
        return v;
    endfunction

    initial begin
        // R1: reset values
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            check("R1 valid", int'(out_valid), 0);
            check("R1 sof", int'(out_sof), 0);
            check("R1 diff", int'(out_diff), 0);
        end
        rst_n = 1'b1;
        idle(2);
        // R2: samples before the first frame marker are dropped
        for (int p = 0; p < 10; p++) send(0, p, 4000 - p);
        // R3: reference frame
        for (int p = 0; p < NPIX; p++) send(p == 0, p, 1000 + 13 * p);
        // R4: small deltas, with idle gaps (R8)
        for (int p = 0; p < NPIX; p++) begin
            send(p == 0, p, clamp12(stim_prev[p] + int'($urandom_range(0, 60)) - 30));
            if (p % 7 == 3) idle(int'($urandom_range(1, 3)));
        end
        // R7: large swings both ways
        for (int p = 0; p < NPIX; p++) send(p == 0, p, (p % 2 == 0) ? 4095 : 0);
        for (int p = 0; p < NPIX; p++) send(p == 0, p, (p % 2 == 0) ? 0 : 4095);
        // R6: odd negative and positive deltas near zero
        for (int p = 0; p < NPIX; p++) send(p == 0, p, 2000);
        for (int p = 0; p < NPIX; p++) send(p == 0, p, 2000 + ((p % 4) * 2 - 3));
        // random frames back to back
        for (int f = 0; f < 3; f++)
            for (int p = 0; p < NPIX; p++) send(p == 0, p, int'($urandom_range(0, 4095)));
        // R5: same index on consecutive cycles
        send(1, 5, 300);
        send(0, 5, 310);
        send(0, 5, 250);
        send(0, 6, 4095);
        send(0, 6, 100);
        idle(6);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule